// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation-buffer miss by searching an inverted, hashed page table in memory. From the 32-bit virtual address it picks one of sixteen segment registers, takes the segment identifier from that register, and hashes the identifier with the page number. The hash and a table base/mask register give the address of a 64-byte group of eight 8-byte entries. The walker reads the entries one at a time through a simple read port. It compares the first big-endian word of each entry against a compare word built from the segment identifier and the page index.

The first match ends the search. If the first (primary) group holds no match, the walker scans a second group. That group's address comes from the complemented hash, and the compare word used there has its hash-identifier bit set. The result is a one-cycle done pulse together with a match flag and the second word of the matching entry. Both group addresses and the primary compare word stay readable after every walk, so a fault or refill handler can use them. Permission checks and result caching belong to the surrounding logic.

Top module: `hpt_walker`

## Requirements
- R1: After reset, and until the first walk starts, `busy_o`, `done_o`, `match_o`, `mem_req_valid_o`, `pte_lo_o`, both group address outputs and both compare outputs are all zero.
- R2: The primary group address is latched when a walk is accepted. It uses segment identifier S = low 24 bits of segment register `vaddr_i[31:28]`, where register k occupies `seg_regs_i[32k+31:32k]`, and hash H = S[18:0] XOR `vaddr_i[27:12]`. The address is {B[31:25], B[24:16] OR (H[18:10] AND B[8:0]), H[9:0], 6'b0}, with B = `table_base_i`.
- R3: The secondary group address is built the same way from H XOR 0x7FFFF. It is latched at the same time on every walk, even when the secondary group is never read.
- R4: Each read request stays asserted with a stable address until it is accepted. Only one read is outstanding at a time. Entries are read at the group address plus 8·i for i = 0..7 in ascending order, the primary group first.
- R5: An entry matches when its word `mem_rsp_data_i[63:32]` equals the compare word {1, S, h, `vaddr_i[27:22]`} (bit 31, bits 30:7, bit 6, bits 5:0), with h = 0 during the primary scan. On the first match the walk stops, `match_o` becomes 1 and `pte_lo_o` takes `mem_rsp_data_i[31:0]`.
- R6: The secondary group is read only when no primary entry matched, and during that scan h = 1. An entry that carries the other scan's compare word does not match.
- R7: When neither group matches, the walk ends after exactly 16 reads with `match_o` = 0 and `pte_lo_o` = 0.
- R8: `done_o` is high for exactly one cycle per walk, in the first cycle in which `busy_o` is low again. `match_o` and `pte_lo_o` then hold until the next accepted start.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The reads, results, group addresses and compare outputs of the running walk are unchanged.
- R10: On an accepted start, the primary compare word (h = 0) goes to `cmp_fetch_o` when `fetch_i` = 1, or else to `cmp_data_o`. The other compare output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 32 | Virtual address that missed |
| fetch_i | input | 1 | 1 for an instruction fetch, 0 for a data access |
| seg_regs_i | input | 512 | Sixteen 32-bit segment registers, register k at bits 32k+31:32k |
| table_base_i | input | 32 | Table origin (bits 31:16) and hash mask (bits 8:0) |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | 32 | Byte address of the entry being read |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data valid (one cycle per request) |
| mem_rsp_data_i | input | 64 | Entry: first word in bits 63:32, second word in bits 31:0 |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| match_o | output | 1 | Last walk found an entry |
| pte_lo_o | output | 32 | Second word of the matching entry, else 0 |
| grp_pri_o | output | 32 | Latched primary group address |
| grp_sec_o | output | 32 | Latched secondary group address |
| cmp_fetch_o | output | 32 | Primary compare word of the last fetch walk |
| cmp_data_o | output | 32 | Primary compare word of the last data walk |

## Verification
A wrong entry index or group select shows up on the first bad request, as an address outside the expected group or out of ascending order. A scan flag stuck at the wrong value shows up as a wrong hash-identifier bit in the compare, and that flips a match decision within one walk. A walk that stops early or runs on shows up as a wrong read count or a missing or doubled done pulse at the end of that walk. A stale latch of the group or compare registers shows up on the outputs in the cycle after the next accepted start.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   // Walk controller states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } walk_state_e;

   // Fixed layout of the entry compare word
   localparam int unsigned CMP_VALID_POS = 31;
   localparam int unsigned CMP_HID_POS   = 6;

endpackage

// File: rtl/hpt_seg_sel.sv
module hpt_seg_sel #(
   parameter int unsigned NUM_SEG = 16,
   parameter int unsigned SEG_W   = 32,
   parameter int unsigned SID_W   = 24,
   localparam int unsigned SEL_W  = $clog2(NUM_SEG)
) (
   input  logic [NUM_SEG*SEG_W-1:0] seg_regs_i,
   input  logic [SEL_W-1:0]         sel_i,
   output logic [SID_W-1:0]         sid_o
);

   logic [SID_W-1:0] term [NUM_SEG];

   // One AND term per segment register, OR-reduced below
   for (genvar k = 0; k < NUM_SEG; k++) begin : g_term
      assign term[k] = (sel_i == SEL_W'(k)) ? seg_regs_i[k*SEG_W +: SID_W] : '0;
   end

   always_comb begin
      sid_o = '0;
      for (int k = 0; k < NUM_SEG; k++) begin
         sid_o = sid_o | term[k];
      end
   end

endmodule

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned HASH_W = 19,
   parameter int unsigned MASK_W = 9,
   parameter int unsigned ORG_LO = 16,
   parameter int unsigned OFF_W  = 6,
   localparam int unsigned HLO_W = ORG_LO - OFF_W,
   localparam int unsigned HHI_W = HASH_W - HLO_W,
   localparam int unsigned MID_HI = ORG_LO + MASK_W
) (
   input  logic [HASH_W-1:0] hash_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] grp_o
);

   logic [MASK_W-1:0] mid;

   // Upper hash bits are gated by the mask and merged into the origin
   assign mid = base_i[MID_HI-1:ORG_LO] |
                (MASK_W'(hash_i[HASH_W-1:HLO_W]) & base_i[MASK_W-1:0]);

   assign grp_o = {base_i[ADDR_W-1:MID_HI], mid, hash_i[HLO_W-1:0], {OFF_W{1'b0}}};

   if (HHI_W != MASK_W) begin : g_bad_split
      $error("hpt_group_addr: upper hash width must equal mask width");
   end

endmodule

// File: rtl/hpt_cmp_word.sv
module hpt_cmp_word #(
   parameter int unsigned SID_W = 24,
   parameter int unsigned API_W = 6,
   localparam int unsigned W    = SID_W + API_W + 2
) (
   input  logic [SID_W-1:0] sid_i,
   input  logic [API_W-1:0] api_i,
   input  logic             hid_i,
   output logic [W-1:0]     cmp_o
);

   assign cmp_o = {1'b1, sid_i, hid_i, api_i};

endmodule

// File: rtl/hpt_scan_fsm.sv
module hpt_scan_fsm
   import hpt_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned GROUP_ENTRIES = 8,
   parameter int unsigned ENTRY_BYTES   = 8,
   localparam int unsigned DATA_W       = ENTRY_BYTES * 8,
   localparam int unsigned WORD_W       = DATA_W / 2,
   localparam int unsigned IDX_W        = $clog2(GROUP_ENTRIES),
   localparam int unsigned ENT_SH       = $clog2(ENTRY_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] grp_pri_i,
   input  logic [ADDR_W-1:0] grp_sec_i,
   input  logic [WORD_W-1:0] cmp_cur_i,
   output logic              second_o,
   output logic              mem_req_valid_o,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   input  logic              mem_req_ready_i,
   input  logic              mem_rsp_valid_i,
   input  logic [DATA_W-1:0] mem_rsp_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              match_o,
   output logic [WORD_W-1:0] pte_lo_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUP_ENTRIES - 1);

   walk_state_e       state;
   logic [IDX_W-1:0]  idx;
   logic              second;
   logic              hit;
   logic [ADDR_W-1:0] grp_cur;

   assign grp_cur  = second ? grp_sec_i : grp_pri_i;
   assign hit      = (mem_rsp_data_i[DATA_W-1:WORD_W] == cmp_cur_i);

   assign mem_req_valid_o = (state == ST_REQ);
   assign mem_req_addr_o  = grp_cur |
                            {{(ADDR_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
   assign busy_o   = (state != ST_IDLE);
   assign second_o = second;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         second   <= 1'b0;
         done_o   <= 1'b0;
         match_o  <= 1'b0;
         pte_lo_o <= '0;
      end else begin
         done_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state    <= ST_REQ;
                  idx      <= '0;
                  second   <= 1'b0;
                  match_o  <= 1'b0;
                  pte_lo_o <= '0;
               end
            end
            ST_REQ: begin
               if (mem_req_ready_i) begin
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid_i) begin
                  if (hit) begin
                     match_o  <= 1'b1;
                     pte_lo_o <= mem_rsp_data_i[WORD_W-1:0];
                     done_o   <= 1'b1;
                     state    <= ST_IDLE;
                  end else if (idx == LAST) begin
                     if (!second) begin
                        second <= 1'b1;
                        idx    <= '0;
                        state  <= ST_REQ;
                     end else begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                     end
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_REQ;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned NUM_SEG       = 16,
   parameter int unsigned SID_W         = 24,
   parameter int unsigned HASH_W        = 19,
   parameter int unsigned API_W         = 6,
   parameter int unsigned MASK_W        = 9,
   parameter int unsigned ORG_LO        = 16,
   parameter int unsigned PG_OFF_W      = 12,
   parameter int unsigned GROUP_ENTRIES = 8,
   parameter int unsigned ENTRY_BYTES   = 8,
   localparam int unsigned SEL_W        = $clog2(NUM_SEG),
   localparam int unsigned OFF_W        = $clog2(GROUP_ENTRIES * ENTRY_BYTES),
   localparam int unsigned PIDX_W       = ADDR_W - SEL_W - PG_OFF_W,
   localparam int unsigned DATA_W       = ENTRY_BYTES * 8,
   localparam int unsigned WORD_W       = DATA_W / 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [ADDR_W-1:0]       vaddr_i,
   input  logic                    fetch_i,
   input  logic [NUM_SEG*32-1:0]   seg_regs_i,
   input  logic [ADDR_W-1:0]       table_base_i,
   output logic                    mem_req_valid_o,
   output logic [ADDR_W-1:0]       mem_req_addr_o,
   input  logic                    mem_req_ready_i,
   input  logic                    mem_rsp_valid_i,
   input  logic [DATA_W-1:0]       mem_rsp_data_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    match_o,
   output logic [WORD_W-1:0]       pte_lo_o,
   output logic [ADDR_W-1:0]       grp_pri_o,
   output logic [ADDR_W-1:0]       grp_sec_o,
   output logic [WORD_W-1:0]       cmp_fetch_o,
   output logic [WORD_W-1:0]       cmp_data_o
);

   // ---------------- elaboration-time parameter checks ----------------
   if (WORD_W != ADDR_W) begin : g_bad_word
      $error("hpt_walker: entry word width must equal address width");
   end
   if (SID_W + API_W + 2 != WORD_W) begin : g_bad_cmp
      $error("hpt_walker: compare word fields do not fill one entry word");
   end
   if (PIDX_W > HASH_W || HASH_W > SID_W) begin : g_bad_hash
      $error("hpt_walker: hash width must cover page index and fit the segment id");
   end
   if (API_W > PIDX_W) begin : g_bad_api
      $error("hpt_walker: page index field wider than page number");
   end
   if (ORG_LO <= OFF_W || ORG_LO + MASK_W >= ADDR_W) begin : g_bad_org
      $error("hpt_walker: table origin split does not fit the address");
   end
   if (CMP_HID_POS != API_W || CMP_VALID_POS != WORD_W - 1) begin : g_bad_layout
      $error("hpt_walker: compare word layout mismatch");
   end

   // ---------------- live hash of the incoming address ----------------
   logic [SID_W-1:0]  sid_live;
   logic [PIDX_W-1:0] page_live;
   logic [API_W-1:0]  api_live;
   logic [HASH_W-1:0] hash_live [2];
   logic [ADDR_W-1:0] grp_live  [2];
   logic [WORD_W-1:0] cmp_live;

   assign page_live = vaddr_i[ADDR_W-SEL_W-1:PG_OFF_W];
   assign api_live  = vaddr_i[ADDR_W-SEL_W-1 -: API_W];

   hpt_seg_sel #(
      .NUM_SEG (NUM_SEG),
      .SEG_W   (32),
      .SID_W   (SID_W)
   ) u_seg_sel (
      .seg_regs_i (seg_regs_i),
      .sel_i      (vaddr_i[ADDR_W-1 -: SEL_W]),
      .sid_o      (sid_live)
   );

   // Probe 0 uses the plain hash, probe 1 its complement
   for (genvar p = 0; p < 2; p++) begin : g_probe
      if (p == 0) begin : g_plain
         assign hash_live[p] = sid_live[HASH_W-1:0] ^ HASH_W'(page_live);
      end else begin : g_inv
         assign hash_live[p] = sid_live[HASH_W-1:0] ^ HASH_W'(page_live) ^ {HASH_W{1'b1}};
      end
      hpt_group_addr #(
         .ADDR_W (ADDR_W),
         .HASH_W (HASH_W),
         .MASK_W (MASK_W),
         .ORG_LO (ORG_LO),
         .OFF_W  (OFF_W)
      ) u_grp (
         .hash_i (hash_live[p]),
         .base_i (table_base_i),
         .grp_o  (grp_live[p])
      );
   end

   hpt_cmp_word #(
      .SID_W (SID_W),
      .API_W (API_W)
   ) u_cmp_live (
      .sid_i (sid_live),
      .api_i (api_live),
      .hid_i (1'b0),
      .cmp_o (cmp_live)
   );

   // ---------------- per-walk latched context ----------------
   logic              start_ok;
   logic [SID_W-1:0]  sid_q;
   logic [API_W-1:0]  api_q;
   logic              second;
   logic [WORD_W-1:0] cmp_cur;

   assign start_ok = start_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sid_q       <= '0;
         api_q       <= '0;
         grp_pri_o   <= '0;
         grp_sec_o   <= '0;
         cmp_fetch_o <= '0;
         cmp_data_o  <= '0;
      end else if (start_ok) begin
         sid_q     <= sid_live;
         api_q     <= api_live;
         grp_pri_o <= grp_live[0];
         grp_sec_o <= grp_live[1];
         if (fetch_i) begin
            cmp_fetch_o <= cmp_live;
         end else begin
            cmp_data_o  <= cmp_live;
         end
      end
   end

   hpt_cmp_word #(
      .SID_W (SID_W),
      .API_W (API_W)
   ) u_cmp_cur (
      .sid_i (sid_q),
      .api_i (api_q),
      .hid_i (second),
      .cmp_o (cmp_cur)
   );

   hpt_scan_fsm #(
      .ADDR_W        (ADDR_W),
      .GROUP_ENTRIES (GROUP_ENTRIES),
      .ENTRY_BYTES   (ENTRY_BYTES)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_ok),
      .grp_pri_i       (grp_pri_o),
      .grp_sec_i       (grp_sec_o),
      .cmp_cur_i       (cmp_cur),
      .second_o        (second),
      .mem_req_valid_o (mem_req_valid_o),
      .mem_req_addr_o  (mem_req_addr_o),
      .mem_req_ready_i (mem_req_ready_i),
      .mem_rsp_valid_i (mem_rsp_valid_i),
      .mem_rsp_data_i  (mem_rsp_data_i),
      .busy_o          (busy_o),
      .done_o          (done_o),
      .match_o         (match_o),
      .pte_lo_o        (pte_lo_o)
   );

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 6,
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              match_o,
   input logic [WORD_W-1:0] pte_lo_o,
   input logic              mem_req_valid_o,
   input logic              mem_req_ready_i,
   input logic [ADDR_W-1:0] mem_req_addr_o,
   input logic [ADDR_W-1:0] grp_pri_o,
   input logic [ADDR_W-1:0] grp_sec_o
);

   // R4: a pending request keeps its address until accepted
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

   // R4: every read falls inside one of the two latched groups, entry aligned
   p_req_in_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000) &&
         ((mem_req_addr_o[ADDR_W-1:OFF_W] == grp_pri_o[ADDR_W-1:OFF_W]) ||
          (mem_req_addr_o[ADDR_W-1:OFF_W] == grp_sec_o[ADDR_W-1:OFF_W])));

   // R8: done is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: done coincides with the walker being idle again
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R8: the match flag changes only at the end of a walk or after a start
   p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(match_o) |-> done_o || $past(start_i));

   // R7: an unsuccessful walk reports a zero low word
   p_nomatch_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !match_o |-> pte_lo_o == '0);

   // R9: latched group addresses stay put while a walk runs
   p_grp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(grp_pri_o) && $stable(grp_sec_o));

   // R9: no memory traffic while idle
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_valid_o);

endmodule

bind hpt_walker hpt_walker_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .busy_o          (busy_o),
   .done_o          (done_o),
   .match_o         (match_o),
   .pte_lo_o        (pte_lo_o),
   .mem_req_valid_o (mem_req_valid_o),
   .mem_req_ready_i (mem_req_ready_i),
   .mem_req_addr_o  (mem_req_addr_o),
   .grp_pri_o       (grp_pri_o),
   .grp_sec_o       (grp_sec_o)
);

// File: tb/test_hpt_walker.sv
module test_hpt_walker;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [31:0]  vaddr_i = '0;
   logic         fetch_i = 1'b0;
   logic [511:0] seg_regs_i = '0;
   logic [31:0]  table_base_i = '0;
   logic         mem_req_valid_o;
   logic [31:0]  mem_req_addr_o;
   logic         mem_req_ready_i = 1'b0;
   logic         mem_rsp_valid_i = 1'b0;
   logic [63:0]  mem_rsp_data_i = '0;
   logic         busy_o, done_o, match_o;
   logic [31:0]  pte_lo_o, grp_pri_o, grp_sec_o, cmp_fetch_o, cmp_data_o;

   hpt_walker i_hpt_walker (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
      .fetch_i(fetch_i), .seg_regs_i(seg_regs_i), .table_base_i(table_base_i),
      .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
      .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
      .mem_rsp_data_i(mem_rsp_data_i), .busy_o(busy_o), .done_o(done_o),
      .match_o(match_o), .pte_lo_o(pte_lo_o), .grp_pri_o(grp_pri_o),
      .grp_sec_o(grp_sec_o), .cmp_fetch_o(cmp_fetch_o), .cmp_data_o(cmp_data_o)
   );

   always #2.5ns clk = ~clk;

   int checks = 0;
   int errors = 0;

   // ---------------- memory model ----------------
   logic        pa_en = 1'b0, pb_en = 1'b0;
   logic [31:0] pa_addr = '0, pa_hi = '0, pa_lo = '0;
   logic [31:0] pb_addr = '0, pb_hi = '0, pb_lo = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   logic [1:0]  wait_cnt = '0;
   logic [31:0] rlog [64];
   int          log_n = 0;
   int          done_cyc = 0;
   int          cyc = 0;

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      if (pa_en && a == pa_addr) return {pa_hi, pa_lo};
      if (pb_en && a == pb_addr) return {pb_hi, pb_lo};
      return {1'b0, a[30:0], ~a};   // valid bit clear: never matches
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done_o) done_cyc <= done_cyc + 1;
      if (mem_req_valid_o && mem_req_ready_i) begin
         pend      <= 1'b1;
         pend_addr <= mem_req_addr_o;
         wait_cnt  <= lfsr[1:0];
         rlog[log_n % 64] <= mem_req_addr_o;
         log_n     <= log_n + 1;
      end else if (mem_rsp_valid_i) begin
         pend <= 1'b0;
      end else if (pend && wait_cnt != 2'd0) begin
         wait_cnt <= wait_cnt - 2'd1;
      end
   end

   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready_i = lfsr[3] | lfsr[7];
      mem_rsp_valid_i = pend && (wait_cnt == 2'd0);
      mem_rsp_data_i  = mem_rsp_valid_i ? mem_word(pend_addr) : 64'h0;
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- reference arithmetic ----------------
   function automatic logic [23:0] ref_sid(input logic [31:0] va);
      logic [31:0] r;
      r = seg_regs_i[va[31:28]*32 +: 32];
      return r[23:0];
   endfunction

   function automatic logic [18:0] ref_hash(input logic [31:0] va);
      logic [23:0] s;
      s = ref_sid(va);
      return s[18:0] ^ {3'b000, va[27:12]};
   endfunction

   function automatic logic [31:0] ref_grp(input logic [18:0] h, input logic [31:0] b);
      return {b[31:25], b[24:16] | (h[18:10] & b[8:0]), h[9:0], 6'b000000};
   endfunction

   function automatic logic [31:0] ref_cmp(input logic [31:0] va, input logic hid);
      return {1'b1, ref_sid(va), hid, va[27:22]};
   endfunction

   task automatic chk(input logic ok, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   logic [31:0] exp_cf = '0, exp_cd = '0;

   // One walk; scen selects planted entries, inject adds a start while busy
   task automatic run_walk(input logic [31:0] va, input logic fe, input int scen,
                           input logic inject);
      logic [31:0] gp, gs, cp, cs, lo_a, lo_b, e_lo;
      logic        e_match, seq_ok;
      int          e_reads, base_n, d0, t;
      gp = ref_grp(ref_hash(va), table_base_i);
      gs = ref_grp(ref_hash(va) ^ 19'h7FFFF, table_base_i);
      cp = ref_cmp(va, 1'b0);
      cs = ref_cmp(va, 1'b1);
      lo_a = 32'hC0DE0000 | 32'(scen);
      lo_b = 32'h5EC00000 | 32'(scen);
      pa_en = 1'b0; pb_en = 1'b0;
      e_match = 1'b0; e_lo = '0; e_reads = 16;
      if (scen >= 1 && scen <= 8) begin
         pa_en = 1'b1; pa_addr = gp + 32'((scen - 1) * 8); pa_hi = cp; pa_lo = lo_a;
         e_match = 1'b1; e_lo = lo_a; e_reads = scen;
      end else if (scen >= 9 && scen <= 16) begin
         pa_en = 1'b1; pa_addr = gs + 32'((scen - 9) * 8); pa_hi = cs; pa_lo = lo_a;
         e_match = 1'b1; e_lo = lo_a; e_reads = scen;
      end else if (scen == 17) begin
         pa_en = 1'b1; pa_addr = gp + 32'd40; pa_hi = cp; pa_lo = lo_a;
         pb_en = 1'b1; pb_addr = gs + 32'd16; pb_hi = cs; pb_lo = lo_b;
         e_match = 1'b1; e_lo = lo_a; e_reads = 6;
      end else if (scen == 18) begin
         pa_en = 1'b1; pa_addr = gp + 32'd24; pa_hi = cs; pa_lo = lo_a;
         pb_en = 1'b1; pb_addr = gs + 32'd24; pb_hi = cp; pb_lo = lo_b;
      end
      if (fe) exp_cf = cp; else exp_cd = cp;
      base_n = log_n;
      d0 = done_cyc;
      vaddr_i = va; fetch_i = fe; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (inject) begin
         repeat (6) @(negedge clk);
         vaddr_i = ~va; fetch_i = ~fe; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      t = 0;
      while (!done_o && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(done_o && !busy_o, "R8 done with busy low", {62'd0, done_o, busy_o}, 64'd2);
      chk(match_o == e_match, "R5/R6/R7 match flag", 64'(match_o), 64'(e_match));
      chk(pte_lo_o == e_lo, "R5/R7 low word", 64'(pte_lo_o), 64'(e_lo));
      chk(log_n - base_n == e_reads, "R6/R7 read count", 64'(log_n - base_n), 64'(e_reads));
      seq_ok = 1'b1;
      for (int k = 0; k < e_reads && k < log_n - base_n; k++) begin
         if (rlog[(base_n + k) % 64] != ((k < 8 ? gp : gs) + 32'((k % 8) * 8))) seq_ok = 1'b0;
      end
      chk(seq_ok, "R4 read address order", 64'(rlog[base_n % 64]), 64'(gp));
      chk(grp_pri_o == gp, "R2 primary group", 64'(grp_pri_o), 64'(gp));
      chk(grp_sec_o == gs, "R3 secondary group", 64'(grp_sec_o), 64'(gs));
      chk(cmp_fetch_o == exp_cf, "R10 fetch compare", 64'(cmp_fetch_o), 64'(exp_cf));
      chk(cmp_data_o == exp_cd, "R10 data compare", 64'(cmp_data_o), 64'(exp_cd));
      repeat (4) @(negedge clk);
      chk(done_cyc - d0 == 1, "R8 single done pulse", 64'(done_cyc - d0), 64'd1);
      chk(match_o == e_match && pte_lo_o == e_lo, "R8 result held",
          {31'd0, match_o, pte_lo_o}, {31'd0, e_match, e_lo});
      if (inject) begin
         chk(log_n - base_n == 16, "R9 start while busy ignored",
             64'(log_n - base_n), 64'd16);
      end
   endtask

   logic [31:0] vas [4];

   initial begin
      for (int k = 0; k < 16; k++) begin
         seg_regs_i[k*32 +: 32] = {4'hF, 4'(k), 24'h5A3C00 ^ 24'(k * 24'h13579)};
      end
      vas[0] = 32'h0000_0000;
      vas[1] = 32'h7ABC_D123;
      vas[2] = 32'hF123_4567;
      vas[3] = 32'h3FFF_F000;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy_o && !done_o && !match_o && !mem_req_valid_o, "R1 reset flags",
          {60'd0, busy_o, done_o, match_o, mem_req_valid_o}, 64'd0);
      chk(pte_lo_o == 0 && grp_pri_o == 0 && grp_sec_o == 0, "R1 reset words",
          64'(pte_lo_o | grp_pri_o | grp_sec_o), 64'd0);
      chk(cmp_fetch_o == 0 && cmp_data_o == 0, "R1 reset compares",
          64'(cmp_fetch_o | cmp_data_o), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy_o && !mem_req_valid_o, "R1 idle after reset",
          {62'd0, busy_o, mem_req_valid_o}, 64'd0);
      for (int b = 0; b < 2; b++) begin
         table_base_i = (b == 0) ? 32'h3E00_0003 : 32'hA0C0_FFFF;
         for (int v = 0; v < 4; v++) begin
            for (int s = 0; s < 19; s++) begin
               run_walk(vas[v] ^ 32'(b * 32'h1111_0000), 1'(s + v), s, 1'b0);
            end
         end
      end
      // R9: start pulse in the middle of an unsuccessful walk
      run_walk(32'h5555_AAAA, 1'b1, 0, 1'b1);
      run_walk(32'h9876_5432, 1'b0, 18, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule